// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block runs the multi-cycle memory traffic that a small 8-bit processor needs for stack transfers and vector fetches. It owns the stack pointer and drives a byte-wide memory bus with one access per clock. The supported operations are subroutine call and return, software break, return from interrupt, reset entry, hardware interrupt entry (maskable or non-maskable), and single-byte push and pull of a register or of the status byte. The surrounding core presents a command code with the current program counter, status byte, register value and jump target on a one-cycle start strobe. After the final bus access the block pulses done. It then holds the new program counter, status byte and pulled register value until the next command.

All stack traffic stays inside page 1, at 0100h to 01FFh. A write first decrements the pointer and then stores at 0100h plus the new pointer. A read fetches from 0100h plus the pointer and then increments it. The pointer wraps within the page. Entry sequences push the return address high byte first and then the status byte. They then read a little-endian vector from one of three fixed pairs of addresses. A non-maskable request is captured on its rising edge and is served ahead of a maskable request. Memory reads are asynchronous: `rd_data` must reflect `bus_addr` within the same cycle.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer reads FFh, and busy, done and the write strobe are low.
- R2: A stack write decrements the pointer and then writes at 0100h plus the new pointer, wrapping 00h to FFh. Register push (code 6) writes `reg_in`, and status push (code 8) writes `p_in`.
- R3: A stack read takes the byte at 0100h plus the pointer and then increments it, wrapping FFh to 00h.
- R4: Call (code 0) pushes PC+2 high byte then low byte, and returns `target_in` as the new PC.
- R5: Return (code 1) pulls the low byte then the high byte, and returns that address plus 1.
- R6: Return from interrupt (code 2) pulls the status byte, then the low byte, then the high byte. It returns the pulled status unchanged and the pulled address as the PC.
- R7: Break (code 3) pushes PC+2 high then low, then the status with bit 4 set. It then reads the vector at FFFEh (low) and FFFFh (high), and returns the status with bit 2 set and bit 3 cleared.
- R8: Interrupt entry (code 4) with a non-maskable request pending (a rising edge on `nmi_in`) uses vector FFFAh/FFFBh even if a maskable request is active. It pushes the PC unmodified, then the status with bit 4 clear, and consumes the pending request.
- R9: With no non-maskable request pending, code 4 enters through FFFEh/FFFFh only when `irq_in` is high and bit 2 of `p_in` is 0. Otherwise it finishes with no bus access and returns `pc_in` and `p_in` unchanged.
- R10: Reset entry (code 5) makes no stack write, leaves the pointer unchanged, reads FFFCh (low) and FFFDh (high), and returns the status with bit 2 set and bit 3 cleared.
- R11: Register pull (code 7) returns the byte on `reg_out`, and status pull (code 9) returns it on `p_out`. Register push and pull return `p_in` unchanged.
- R12: Bus accesses occur on consecutive cycles starting the cycle after start is taken. Done is high for exactly one cycle, the cycle after the last access, and the results are valid from that cycle onward.
- R13: A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| op_in | input | 4 | Command code (0 to 9) |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte |
| reg_in | input | 8 | Register value for a push |
| target_in | input | 16 | Jump target for call |
| irq_in | input | 1 | Maskable interrupt request (level) |
| nmi_in | input | 1 | Non-maskable request (rising edge) |
| rd_data | input | 8 | Memory read data for `bus_addr` |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Memory write strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| p_out | output | 8 | Resulting status byte |
| reg_out | output | 8 | Last pulled register byte |
| sp_out | output | 8 | Stack pointer |

## Verification
The sequences are run against a stack page filled with distinct bytes and vectors with distinct halves. This catches any swap of the high and low bytes, or of status and address order, and shows it as a wrong address or value. Pulls and pushes at the pointer extremes show whether the wrap stays inside page 1. Break, maskable and non-maskable entry are run with different status bytes, some with D set and some with B set. The pushed B bit and the returned I and D bits then separate software entry from hardware entry. Interrupt entry is also tried with masking set, with both requests active, and after the edge has already been consumed. These runs separate priority, masking and clearing of the pending request.

// File: rtl/stack_seq_pkg.sv
`timescale 1ns/1ps
package stack_seq_pkg;
  localparam int STEP_W = 3;
  localparam logic [7:0] FLAG_B = 8'h10;
  localparam logic [7:0] FLAG_D = 8'h08;
  localparam logic [7:0] FLAG_I = 8'h04;
  localparam logic [15:0] VEC_NMI = 16'hFFFA;
  localparam logic [15:0] VEC_RST = 16'hFFFC;
  localparam logic [15:0] VEC_IRQ = 16'hFFFE;

  typedef enum logic [3:0] {
    OP_CALL = 4'd0, OP_RET = 4'd1, OP_RTI = 4'd2, OP_BRK = 4'd3, OP_INT = 4'd4,
    OP_RST = 4'd5, OP_PUSHR = 4'd6, OP_PULLR = 4'd7, OP_PUSHP = 4'd8,
    OP_PULLP = 4'd9, OP_IDLE = 4'd15
  } op_e;

  typedef enum logic [3:0] {
    AC_NONE, AC_WPCH, AC_WPCL, AC_WP, AC_WREG,
    AC_RLO, AC_RHI, AC_RP, AC_RREG, AC_VLO, AC_VHI
  } acc_e;

  // Bus access performed at a given step of a command.
  function automatic acc_e step_acc(op_e op, logic [STEP_W-1:0] st);
    acc_e a;
    a = AC_NONE;
    case (op)
      OP_CALL: a = (st == 3'd0) ? AC_WPCH : (st == 3'd1) ? AC_WPCL : AC_NONE;
      OP_RET:  a = (st == 3'd0) ? AC_RLO : (st == 3'd1) ? AC_RHI : AC_NONE;
      OP_RTI:  a = (st == 3'd0) ? AC_RP : (st == 3'd1) ? AC_RLO :
                   (st == 3'd2) ? AC_RHI : AC_NONE;
      OP_BRK, OP_INT: begin
        case (st)
          3'd0: a = AC_WPCH;
          3'd1: a = AC_WPCL;
          3'd2: a = AC_WP;
          3'd3: a = AC_VLO;
          3'd4: a = AC_VHI;
          default: a = AC_NONE;
        endcase
      end
      OP_RST:   a = (st == 3'd0) ? AC_VLO : (st == 3'd1) ? AC_VHI : AC_NONE;
      OP_PUSHR: a = (st == 3'd0) ? AC_WREG : AC_NONE;
      OP_PULLR: a = (st == 3'd0) ? AC_RREG : AC_NONE;
      OP_PUSHP: a = (st == 3'd0) ? AC_WP : AC_NONE;
      OP_PULLP: a = (st == 3'd0) ? AC_RP : AC_NONE;
      default:  a = AC_NONE;
    endcase
    return a;
  endfunction

  function automatic logic [7:0] entry_flags(logic [7:0] p);
    return (p | FLAG_I) & ~FLAG_D;
  endfunction

  function automatic logic [15:0] ret_addr(logic [15:0] pc);
    return pc + 16'd2;
  endfunction
endpackage

// File: rtl/stack_ptr.sv
`timescale 1ns/1ps
module stack_ptr #(
  parameter logic [7:0] SP_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec,
  input  logic       inc,
  output logic [7:0] sp,
  output logic [7:0] sp_dn
);
  logic [7:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_INIT;
    else if (dec) sp_q <= sp_q - 8'd1;
    else if (inc) sp_q <= sp_q + 8'd1;
  end

  assign sp    = sp_q;
  assign sp_dn = sp_q - 8'd1;

  // R3: the sequencer never asks for both directions in one cycle
  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n) !(dec && inc));
endmodule

// File: rtl/nmi_edge.sv
`timescale 1ns/1ps
module nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic nmi_q, pend_q, rise;

  assign rise = nmi_in & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_in;
      pend_q <= rise | (pend_q & ~take);
    end
  end

  assign pend = pend_q;

  // R8: a served request is consumed unless a new edge arrives
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rise) |=> !pend);
endmodule

// File: rtl/stack_seq.sv
`timescale 1ns/1ps
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_INIT    = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op_in,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  reg_in,
  input  logic [15:0] target_in,
  input  logic        irq_in,
  input  logic        nmi_in,
  input  logic [7:0]  rd_data,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  output logic        bus_we,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [7:0]  p_out,
  output logic [7:0]  reg_out,
  output logic [7:0]  sp_out
);
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  op_e               op_q;
  logic [15:0]       pc_q, tgt_q, vec_q;
  logic [7:0]        p_q, reg_q, lo_q, hi_q, pp_q, rr_q;

  // named internal events
  acc_e        acc;
  logic        accept, finish, is_wr, is_srd, is_vrd;
  logic        nmi_pend, nmi_take, irq_ok;
  op_e         op_cmd, op_eff;
  logic [15:0] vec_sel, pc_push;
  logic [7:0]  p_push, sp_q, sp_dn;

  assign acc    = busy_q ? step_acc(op_q, step_q) : AC_NONE;
  assign accept = start && !busy_q;
  assign finish = busy_q && (acc == AC_NONE);
  assign is_wr  = (acc == AC_WPCH) || (acc == AC_WPCL) || (acc == AC_WP) || (acc == AC_WREG);
  assign is_srd = (acc == AC_RLO) || (acc == AC_RHI) || (acc == AC_RP) || (acc == AC_RREG);
  assign is_vrd = (acc == AC_VLO) || (acc == AC_VHI);

  assign op_cmd   = op_e'(op_in);
  assign irq_ok   = irq_in && !p_in[2];
  assign nmi_take = accept && (op_cmd == OP_INT) && nmi_pend;

  always_comb begin
    case (op_cmd)
      OP_CALL, OP_RET, OP_RTI, OP_BRK, OP_RST,
      OP_PUSHR, OP_PULLR, OP_PUSHP, OP_PULLP: op_eff = op_cmd;
      OP_INT:  op_eff = (nmi_pend || irq_ok) ? OP_INT : OP_IDLE;
      default: op_eff = OP_IDLE;
    endcase
    if (op_cmd == OP_RST)   vec_sel = VEC_RST;
    else if (nmi_take)      vec_sel = VEC_NMI;
    else                    vec_sel = VEC_IRQ;
  end

  stack_ptr #(.SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n), .dec(is_wr), .inc(is_srd), .sp(sp_q), .sp_dn(sp_dn)
  );

  nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .take(nmi_take), .pend(nmi_pend)
  );

  // command sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_IDLE;
      pc_q   <= '0;
      tgt_q  <= '0;
      vec_q  <= '0;
      p_q    <= '0;
      reg_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= '0;
      op_q   <= op_eff;
      pc_q   <= pc_in;
      tgt_q  <= target_in;
      vec_q  <= vec_sel;
      p_q    <= p_in;
      reg_q  <= reg_in;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
    end
  end

  // capture of read bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      pp_q <= '0;
      rr_q <= '0;
    end else begin
      if (acc == AC_RLO || acc == AC_VLO) lo_q <= rd_data;
      if (acc == AC_RHI || acc == AC_VHI) hi_q <= rd_data;
      if (acc == AC_RP)                   pp_q <= rd_data;
      if (acc == AC_RREG)                 rr_q <= rd_data;
    end
  end

  assign pc_push = (op_q == OP_CALL || op_q == OP_BRK) ? ret_addr(pc_q) : pc_q;
  assign p_push  = (op_q == OP_BRK) ? (p_q | FLAG_B) :
                   (op_q == OP_INT) ? (p_q & ~FLAG_B) : p_q;

  always_comb begin
    case (acc)
      AC_WPCH: bus_wdata = pc_push[15:8];
      AC_WPCL: bus_wdata = pc_push[7:0];
      AC_WP:   bus_wdata = p_push;
      AC_WREG: bus_wdata = reg_q;
      default: bus_wdata = 8'h00;
    endcase
    if (is_wr)       bus_addr = {STACK_PAGE, sp_dn};
    else if (is_srd) bus_addr = {STACK_PAGE, sp_q};
    else if (is_vrd) bus_addr = vec_q + {15'd0, acc == AC_VHI};
    else             bus_addr = 16'h0000;
  end

  always_comb begin
    case (op_q)
      OP_CALL:                 pc_out = tgt_q;
      OP_RET:                  pc_out = {hi_q, lo_q} + 16'd1;
      OP_RTI, OP_BRK, OP_INT,
      OP_RST:                  pc_out = {hi_q, lo_q};
      default:                 pc_out = pc_q;
    endcase
    case (op_q)
      OP_RTI, OP_PULLP:        p_out = pp_q;
      OP_BRK, OP_INT, OP_RST:  p_out = entry_flags(p_q);
      default:                 p_out = p_q;
    endcase
  end

  assign bus_we  = is_wr;
  assign busy    = busy_q;
  assign done    = finish;
  assign reg_out = rr_q;
  assign sp_out  = sp_q;

  // R2: every write lands in the stack page
  p_wr_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_addr[15:8] == STACK_PAGE);
  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: reset entry never writes
  p_reset_no_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_RST) |-> !bus_we);
  // R7: vector fetches are reads in the top vector block
  p_vec_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_vrd |-> (!bus_we && bus_addr[15:3] == 13'h1FFF));
  // R13: a strobe during a command leaves the command in place
  p_ignore_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish && start) |=> (busy_q && $stable(op_q)));
endmodule

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_in = 4'd0;
  logic [15:0] pc_in = 16'h0, target_in = 16'h0;
  logic [7:0]  p_in = 8'h0, reg_in = 8'h0;
  logic        irq_in = 1'b0, nmi_in = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, p_out, reg_out, sp_out;
  logic        bus_we, busy, done;

  int errors = 0;
  int checks = 0;

  logic [7:0] stk  [256];
  logic [7:0] vmem [8];
  // model state
  int mstk [256];
  int msp = 255;
  int mreg = 0;
  bit mnmi = 0;
  int qa[$], qw[$], qd[$];

  always #4 clk = ~clk;

  stack_seq u_stack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .pc_in(pc_in),
    .p_in(p_in), .reg_in(reg_in), .target_in(target_in), .irq_in(irq_in),
    .nmi_in(nmi_in), .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .busy(busy), .done(done), .pc_out(pc_out), .p_out(p_out),
    .reg_out(reg_out), .sp_out(sp_out)
  );

  always_comb begin
    if (bus_addr[15:8] == 8'h01)        rd_data = stk[bus_addr[7:0]];
    else if (bus_addr[15:3] == 13'h1FFF) rd_data = vmem[bus_addr[2:0]];
    else                                 rd_data = 8'h00;
  end

  always @(posedge clk) if (bus_we && bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic mpush(input int v);
    msp = (msp + 255) % 256;
    mstk[msp] = v & 255;
    qa.push_back(256 + msp); qw.push_back(1); qd.push_back(v & 255);
  endtask

  task automatic mpull(output int v);
    v = mstk[msp];
    qa.push_back(256 + msp); qw.push_back(0); qd.push_back(0);
    msp = (msp + 1) % 256;
  endtask

  task automatic mvec(input int a, output int v);
    v = int'(vmem[a % 8]);
    qa.push_back(a); qw.push_back(0); qd.push_back(0);
  endtask

  task automatic run(input int op, input int pc, input int p, input int rg, input int tg,
                     input bit poke, input string tag);
    int epc, ep, lo, hi, r, base;
    bit take;
    qa.delete(); qw.delete(); qd.delete();
    epc = pc; ep = p; lo = 0; hi = 0; take = 0; base = 0;
    case (op)
      0: begin r = (pc + 2) % 65536; mpush(r / 256); mpush(r % 256); epc = tg; end
      1: begin mpull(lo); mpull(hi); epc = (hi * 256 + lo + 1) % 65536; end
      2: begin mpull(ep); mpull(lo); mpull(hi); epc = hi * 256 + lo; end
      3: begin
        r = (pc + 2) % 65536; mpush(r / 256); mpush(r % 256); mpush(p | 16);
        mvec(16'hFFFE, lo); mvec(16'hFFFF, hi);
        epc = hi * 256 + lo; ep = (p | 4) & 8'hF7;
      end
      4: begin
        if (mnmi) begin take = 1; base = 16'hFFFA; mnmi = 0; end
        else if (irq_in && (p & 4) == 0) begin take = 1; base = 16'hFFFE; end
        if (take) begin
          mpush(pc / 256); mpush(pc % 256); mpush(p & 8'hEF);
          mvec(base, lo); mvec(base + 1, hi);
          epc = hi * 256 + lo; ep = (p | 4) & 8'hF7;
        end
      end
      5: begin mvec(16'hFFFC, lo); mvec(16'hFFFD, hi); epc = hi * 256 + lo; ep = (p | 4) & 8'hF7; end
      6: mpush(rg);
      7: mpull(mreg);
      8: mpush(p);
      9: mpull(ep);
      default: ;
    endcase
    start = 1'b1; op_in = op[3:0]; pc_in = pc[15:0]; p_in = p[7:0];
    reg_in = rg[7:0]; target_in = tg[15:0];
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < qa.size(); i++) begin
      check(tag, "bus_addr", bus_addr, qa[i]);
      check(tag, "bus_we", bus_we, qw[i]);
      if (qw[i] == 1) check(tag, "bus_wdata", bus_wdata, qd[i]);
      check("R12", "done early", done, 0);
      if (poke && i == 0) begin start = 1'b1; op_in = 4'd6; end
      @(negedge clk); start = 1'b0;
    end
    check("R12", "done", done, 1);
    check("R12", "bus_we at done", bus_we, 0);
    check(tag, "pc_out", pc_out, epc);
    check(tag, "p_out", p_out, ep);
    check(tag, "reg_out", reg_out, mreg);
    check(tag, "sp_out", sp_out, msp);
    @(negedge clk);
    check("R12", "done pulse", done, 0);
    check("R12", "busy after", busy, 0);
    if (poke) check("R13", "sp after ignored start", sp_out, msp);
  endtask

  task automatic pulse_nmi();
    nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    mnmi = 1;
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL R12 watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      stk[i] = 8'(i ^ 8'h5A);
      mstk[i] = (i ^ 8'h5A) & 255;
    end
    vmem[0] = 8'h01; vmem[1] = 8'h02; vmem[2] = 8'h11; vmem[3] = 8'h22;
    vmem[4] = 8'h33; vmem[5] = 8'h44; vmem[6] = 8'h55; vmem[7] = 8'h66;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "sp reset", sp_out, 8'hFF);
    check("R1", "busy reset", busy, 0);
    check("R1", "done reset", done, 0);
    check("R1", "we reset", bus_we, 0);
    @(negedge clk);

    run(7, 16'h0100, 8'h00, 8'h00, 0, 0, "R3");      // pull at 01FF, pointer wraps to 00
    run(6, 16'h0100, 8'h00, 8'h3C, 0, 0, "R2");      // push wraps back to FF
    run(8, 16'h0100, 8'hA5, 8'h00, 0, 0, "R2");
    run(9, 16'h0100, 8'h00, 8'h00, 0, 0, "R11");
    run(6, 16'h0100, 8'h81, 8'h77, 0, 0, "R11");
    run(7, 16'h0100, 8'h81, 8'h00, 0, 0, "R11");
    run(0, 16'h1234, 8'h00, 8'h00, 16'h8000, 1, "R4 R13");
    run(1, 16'h8000, 8'h00, 8'h00, 0, 0, "R5");
    run(3, 16'h2000, 8'h0A, 8'h00, 0, 0, "R7");
    run(2, 16'h6655, 8'h06, 8'h00, 0, 0, "R6");
    irq_in = 1'b1;
    run(4, 16'h3000, 8'h10, 8'h00, 0, 0, "R9");      // taken, B cleared in pushed status
    run(2, 16'h6655, 8'h04, 8'h00, 0, 0, "R6");
    run(4, 16'h3100, 8'h04, 8'h00, 0, 0, "R9");      // masked: no access
    pulse_nmi();
    run(4, 16'h5000, 8'h08, 8'h00, 0, 0, "R8");      // NMI wins over active IRQ
    run(2, 16'h2211, 8'h04, 8'h00, 0, 0, "R6");
    irq_in = 1'b0;
    run(4, 16'h5100, 8'h00, 8'h00, 0, 0, "R8");      // request already consumed
    run(5, 16'h0000, 8'h08, 8'h00, 0, 0, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule